// File: doc/BRIEF.md
# Low-Resolution RGB Video Timing Generator

This block produces the complete timing and pixel stream for a progressive, 240-line colour display running at about 60 frames per second, with one on/off bit per colour. A horizontal timer advances once per pixel strobe and splits every line into four phases. A vertical timer advances once per finished line and splits every frame the same way. Both sync outputs are active low. A composite sync is formed as the AND of the two, so horizontal pulses still pass through the combining logic while the frame is being drawn, and the composite sync stays low for the whole vertical pulse.

While the beam is inside the visible area, a built-in pattern divides each line into eight equal-width colour bars. Outside that area all three colour bits are held low. A heartbeat output counts vertical sync pulses and changes level after a set number of them, which gives a visible blink of roughly one second at the default settings. All outputs are registered and change on the same clock edge.

Each timer is a four-state machine with the states `PH_ACTIVE`, `PH_FRONT`, `PH_SYNC` and `PH_BACK`, and a position counter within the current state. On a step, the timer moves from one state to the next when the position reaches that state's length minus one, and the position then restarts at zero. The transitions are ACTIVE→FRONT at the end of the visible span, FRONT→SYNC at the end of the front porch, SYNC→BACK at the end of the sync pulse, and BACK→ACTIVE at the end of the back porch. The BACK→ACTIVE transition of the horizontal timer is the line wrap, and it steps the vertical timer. With the default parameters a frame is 240+3+3+16 = 262 lines and a line is 256+16+24+24 = 320 pixel strobes.

Top module: `rgb_timing_gen`

## Requirements
- R1: A line has H_ACTIVE + H_FRONT + H_SYNC + H_BACK pixel strobes. The horizontal position advances only in clock cycles where `pix_en` is high, and it returns to 0 after the last back-porch strobe.
- R2: A frame has V_ACTIVE + V_FRONT + V_SYNC + V_BACK lines. The line number advances once, when the horizontal position wraps, and returns to line 0 after the last back-porch line.
- R3: `hsync_n` is low exactly while the horizontal position is in [H_ACTIVE+H_FRONT, H_ACTIVE+H_FRONT+H_SYNC). It is high otherwise.
- R4: `vsync_n` is low exactly while the line number is in [V_ACTIVE+V_FRONT, V_ACTIVE+V_FRONT+V_SYNC). It is high otherwise, so it is low for whole lines only.
- R5: `csync_n` always equals `hsync_n & vsync_n`.
- R6: `red`, `green` and `blue` are all 0 whenever the horizontal position is at or beyond H_ACTIVE, or the line number is at or beyond V_ACTIVE. This covers both retrace intervals.
- R7: Inside the visible area, the pixel at horizontal position x belongs to bar k = x / (H_ACTIVE/8). The outputs are then red = k[2], green = k[1] and blue = k[0], so bar 0 is black and bar 7 is white.
- R8: `heartbeat` changes level on the same clock edge as the HB_FRAMES-th falling edge of `vsync_n` counted since the last change or since reset. It changes at no other edge.
- R9: A synchronous active-high `rst` drives `hsync_n`, `vsync_n` and `csync_n` high and `red`, `green`, `blue` and `heartbeat` low. It moves the position to pixel 0 of line 0 and clears the frame count.
- R10: All outputs are registered. Each output reflects the position held before the clock edge, so when `pix_en` is low for two cycles in a row, no output changes at the second edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Pixel strobe; one pixel time per high cycle |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| csync_n | output | 1 | Composite sync, AND of both syncs |
| red | output | 1 | Red on/off |
| green | output | 1 | Green on/off |
| blue | output | 1 | Blue on/off |
| heartbeat | output | 1 | Level that toggles every HB_FRAMES frames |

## Verification
The assertions assume that `pix_en` is a plain level sampled on each clock, with no minimum spacing. They also assume that every phase length parameter is at least 1, that H_ACTIVE is a multiple of 8, and that `rst` may arrive in any cycle, including in the middle of a line. The stimulus keeps to this. It drives the strobe at random with a fixed seed, holds it high for a long directed run, parks it low for a long stretch, and pulses reset in the middle of a frame. Small timing parameters let many frames, and therefore several heartbeat toggles, fit in the run.

// File: rtl/rgb_timing_pkg.sv
package rgb_timing_pkg;

    // Phases shared by the horizontal and vertical timers.
    typedef enum logic [1:0] {
        PH_ACTIVE = 2'd0,
        PH_FRONT  = 2'd1,
        PH_SYNC   = 2'd2,
        PH_BACK   = 2'd3
    } phase_t;

endpackage

// File: rtl/rgb_axis_timer.sv
module rgb_axis_timer
    import rgb_timing_pkg::*;
#(
    parameter  int ACTIVE = 256,
    parameter  int FRONT  = 16,
    parameter  int SYNC   = 24,
    parameter  int BACK   = 24,
    localparam int TOTAL  = ACTIVE + FRONT + SYNC + BACK,
    localparam int CW     = $clog2(TOTAL + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output phase_t        phase,
    output logic [CW-1:0] pos,
    output logic          wrap
);

    phase_t        phase_nx;
    logic [CW-1:0] span;
    logic          last;

    // Length of the current phase and the phase that follows it.
    always_comb begin
        span     = CW'(ACTIVE);
        phase_nx = PH_FRONT;
        unique case (phase)
            PH_ACTIVE: begin span = CW'(ACTIVE); phase_nx = PH_FRONT;  end
            PH_FRONT:  begin span = CW'(FRONT);  phase_nx = PH_SYNC;   end
            PH_SYNC:   begin span = CW'(SYNC);   phase_nx = PH_BACK;   end
            PH_BACK:   begin span = CW'(BACK);   phase_nx = PH_ACTIVE; end
        endcase
    end

    assign last = (pos == span - 1'b1);
    assign wrap = step && last && (phase == PH_BACK);

    // State register: the phase and the position within it.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_ACTIVE;
            pos   <= '0;
        end else if (step) begin
            if (last) begin
                phase <= phase_nx;
                pos   <= '0;
            end else begin
                pos <= pos + 1'b1;
            end
        end
    end

    AST_POS_IN_SPAN: assert property (@(posedge clk) disable iff (rst) pos < span); // R1
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !step |=> ($stable(phase) && $stable(pos))); // R1
    AST_WRAP_TO_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (phase == PH_ACTIVE && pos == '0)); // R1

endmodule

// File: rtl/rgb_bar_pattern.sv
module rgb_bar_pattern #(
    parameter  int ACTIVE = 256,
    parameter  int CW     = 9,
    localparam int BAR_W  = ACTIVE / 8
) (
    input  logic [CW-1:0] x,
    output logic [2:0]    color
);

    // One threshold per bar boundary; the bar index is how many lie behind x.
    logic [7:1] passed;

    for (genvar k = 1; k < 8; k++) begin : g_edge
        assign passed[k] = (x >= CW'(k * BAR_W));
    end

    always_comb color = 3'($countones(passed));

endmodule

// File: rtl/rgb_heartbeat.sv
module rgb_heartbeat #(
    parameter  int FRAMES = 30,
    localparam int HW     = $clog2(FRAMES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic beat
);

    logic [HW-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= '0;
            beat <= 1'b0;
        end else if (tick) begin
            if (seen == HW'(FRAMES - 1)) begin
                seen <= '0;
                beat <= ~beat;
            end else begin
                seen <= seen + 1'b1;
            end
        end
    end

    AST_BEAT_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(beat)); // R8
    AST_SEEN_BOUND: assert property (@(posedge clk) disable iff (rst)
        seen < HW'(FRAMES)); // R8

endmodule

// File: rtl/rgb_timing_gen.sv
module rgb_timing_gen
    import rgb_timing_pkg::*;
#(
    parameter  int H_ACTIVE  = 256,
    parameter  int H_FRONT   = 16,
    parameter  int H_SYNC    = 24,
    parameter  int H_BACK    = 24,
    parameter  int V_ACTIVE  = 240,
    parameter  int V_FRONT   = 3,
    parameter  int V_SYNC    = 3,
    parameter  int V_BACK    = 16,
    parameter  int HB_FRAMES = 30,
    localparam int H_TOTAL   = H_ACTIVE + H_FRONT + H_SYNC + H_BACK,
    localparam int V_TOTAL   = V_ACTIVE + V_FRONT + V_SYNC + V_BACK,
    localparam int HCW       = $clog2(H_TOTAL + 1),
    localparam int VCW       = $clog2(V_TOTAL + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic pix_en,
    output logic hsync_n,
    output logic vsync_n,
    output logic csync_n,
    output logic red,
    output logic green,
    output logic blue,
    output logic heartbeat
);

    phase_t           h_phase;
    phase_t           v_phase;
    logic [HCW-1:0]   h_pos;
    logic [VCW-1:0]   v_pos;
    logic             h_wrap;
    logic             v_wrap;
    logic [2:0]       bar_rgb;
    logic             beat_tick;

    rgb_axis_timer #(
        .ACTIVE(H_ACTIVE), .FRONT(H_FRONT), .SYNC(H_SYNC), .BACK(H_BACK)
    ) u_htim (
        .clk(clk), .rst(rst), .step(pix_en),
        .phase(h_phase), .pos(h_pos), .wrap(h_wrap)
    );

    rgb_axis_timer #(
        .ACTIVE(V_ACTIVE), .FRONT(V_FRONT), .SYNC(V_SYNC), .BACK(V_BACK)
    ) u_vtim (
        .clk(clk), .rst(rst), .step(h_wrap),
        .phase(v_phase), .pos(v_pos), .wrap(v_wrap)
    );

    rgb_bar_pattern #(
        .ACTIVE(H_ACTIVE), .CW(HCW)
    ) u_bars (
        .x(h_pos), .color(bar_rgb)
    );

    // One tick on the edge where the registered vsync goes low.
    assign beat_tick = vsync_n && (v_phase == PH_SYNC);

    rgb_heartbeat #(
        .FRAMES(HB_FRAMES)
    ) u_beat (
        .clk(clk), .rst(rst), .tick(beat_tick), .beat(heartbeat)
    );

    // Output process: every pin registered from the timer phases.
    always_ff @(posedge clk) begin
        if (rst) begin
            hsync_n <= 1'b1;
            vsync_n <= 1'b1;
            csync_n <= 1'b1;
            {red, green, blue} <= 3'b000;
        end else begin
            hsync_n <= (h_phase != PH_SYNC);
            vsync_n <= (v_phase != PH_SYNC);
            csync_n <= (h_phase != PH_SYNC) && (v_phase != PH_SYNC);
            if (h_phase == PH_ACTIVE && v_phase == PH_ACTIVE)
                {red, green, blue} <= bar_rgb;
            else
                {red, green, blue} <= 3'b000;
        end
    end

    AST_CSYNC_IS_AND: assert property (@(posedge clk) disable iff (rst)
        csync_n == (hsync_n & vsync_n)); // R5
    AST_RGB_BLANKED: assert property (@(posedge clk) disable iff (rst)
        (!hsync_n || !vsync_n) |-> ({red, green, blue} == 3'b000)); // R6
    AST_VSYNC_ON_LINE_EDGE: assert property (@(posedge clk) disable iff (rst)
        $fell(vsync_n) |-> $past(h_wrap, 2)); // R4
    AST_FRAME_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        v_wrap |=> (v_phase == PH_ACTIVE && v_pos == '0 && h_phase == PH_ACTIVE && h_pos == '0)); // R2
    AST_IDLE_OUTPUTS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!pix_en && !$past(pix_en) && !$past(rst)) |=>
        $stable({hsync_n, vsync_n, csync_n, red, green, blue, heartbeat})); // R10

endmodule

// File: tb/tb_rgb_timing_gen.sv
`timescale 1ns/1ps
module tb_rgb_timing_gen;

    localparam int HA  = 16;
    localparam int HF  = 2;
    localparam int HS  = 3;
    localparam int HB  = 3;
    localparam int VA  = 4;
    localparam int VF  = 1;
    localparam int VS  = 2;
    localparam int VB  = 1;
    localparam int HBF = 3;
    localparam int HT  = HA + HF + HS + HB;
    localparam int VT  = VA + VF + VS + VB;
    localparam int NCYC = 8000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pix_en = 1'b0;
    logic hsync_n, vsync_n, csync_n, red, green, blue, heartbeat;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rgb_timing_gen #(
        .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
        .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB),
        .HB_FRAMES(HBF)
    ) dut (
        .clk(clk), .rst(rst), .pix_en(pix_en),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .csync_n(csync_n),
        .red(red), .green(green), .blue(blue), .heartbeat(heartbeat)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_hs(input int x);
        return !(x >= HA + HF && x < HA + HF + HS);
    endfunction

    function automatic logic exp_vs(input int y);
        return !(y >= VA + VF && y < VA + VF + VS);
    endfunction

    function automatic logic [2:0] exp_rgb(input int x, input int y);
        if (x < HA && y < VA) return 3'(x / (HA / 8));
        return 3'b000;
    endfunction

    // Model state: position before the next edge.
    int hx = 0;
    int vy = 0;
    int hbc = 0;
    logic hb = 1'b0;
    logic vs_prev = 1'b1;
    logic [6:0] snap;

    initial begin
        void'($urandom(32'h5eed_1234));
        // Reset state, R9
        repeat (3) @(posedge clk);
        #5;
        chk("R9 hsync_n in reset", 8'(hsync_n), 8'd1);
        chk("R9 vsync_n in reset", 8'(vsync_n), 8'd1);
        chk("R9 csync_n in reset", 8'(csync_n), 8'd1);
        chk("R9 rgb in reset", 8'({red, green, blue}), 8'd0);
        chk("R9 heartbeat in reset", 8'(heartbeat), 8'd0);

        for (int c = 0; c < NCYC; c++) begin
            logic en, r, ehs, evs, ehb;
            logic [2:0] ergb;
            @(negedge clk);
            // Directed phases: long run of strobes, idle stretch, reset pulse.
            if (c < 600) en = 1'b1;
            else if (c >= 2000 && c < 2060) en = 1'b0;
            else en = ($urandom % 4) != 0;
            r = (c == 4100 || c == 4101);
            pix_en = en;
            rst = r;

            if (r) begin
                ehs = 1'b1; evs = 1'b1; ergb = 3'b000; ehb = 1'b0;
                hx = 0; vy = 0; hbc = 0; hb = 1'b0; vs_prev = 1'b1;
            end else begin
                ehs = exp_hs(hx);
                evs = exp_vs(vy);
                ergb = exp_rgb(hx, vy);
                if (vs_prev && !evs) begin
                    hbc++;
                    if (hbc == HBF) begin
                        hb = !hb;
                        hbc = 0;
                    end
                end
                ehb = hb;
                vs_prev = evs;
                if (en) begin
                    hx++;
                    if (hx == HT) begin
                        hx = 0;
                        vy++;
                        if (vy == VT) vy = 0;
                    end
                end
            end

            @(posedge clk);
            #5;
            if (r) begin
                chk("R9 syncs after mid-frame reset", 8'({hsync_n, vsync_n, csync_n}), 8'b111);
                chk("R9 rgb/heartbeat after mid-frame reset", 8'({red, green, blue, heartbeat}), 8'd0);
            end else begin
                chk("R3 hsync_n (R1 line timing)", 8'(hsync_n), 8'(ehs));
                chk("R4 vsync_n (R2 frame timing)", 8'(vsync_n), 8'(evs));
                chk("R5 csync_n", 8'(csync_n), 8'(ehs & evs));
                if (ergb == 3'b000 && !(hx < HA && vy < VA))
                    chk("R6 rgb blanked", 8'({red, green, blue}), 8'(ergb));
                else
                    chk("R7 colour bar", 8'({red, green, blue}), 8'(ergb));
                chk("R8 heartbeat", 8'(heartbeat), 8'(ehb));
            end

            if (c == 2002) snap = {hsync_n, vsync_n, csync_n, red, green, blue, heartbeat};
            if (c == 2059)
                chk("R10 outputs hold while strobe idle",
                    8'({hsync_n, vsync_n, csync_n, red, green, blue, heartbeat}), 8'(snap));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule